// File: doc/BRIEF.md
# Redundant Clock Failure Detector and Switch

This block oversees two redundant reference clocks and chooses which of them drives a downstream reference output. A fast, free-running monitor clock samples both references through synchronizers. A per-input counter restarts on every level change of its input. If an input holds one level, high or low, for a programmable number of monitor cycles that stands for one nominal input period, the block raises a sticky bad flag for that input. Both inputs are watched all the time, whichever one is selected.

When the selected input goes bad and the other input is still good, the selection moves to the other input. A failure on the unselected input only raises its own flag. When both inputs are bad, the selection stays where it is. A manual override hands the choice of source to the select input and stops automatic switching. An alarm-clear pulse drops the flags and restarts the watch. A synchronous master reset clears everything and loads the selection from the select input.

The reference output is rebuilt in the monitor domain. It changes source only while it is held low, so a switch never produces a runt pulse.

Top module: `redclk_switch`

## Requirements
- R1: Both inputs are monitored at all times. A stuck input that is not selected still has its bad flag set.
- R2: An input that shows no level change for NOM_PERIOD monitor cycles, whether stuck high or stuck low, gets its bad flag set. An input that keeps toggling faster than that is never flagged.
- R3: A bad flag stays high until alarm_clr or mrst is sampled high, even if its input starts toggling again.
- R4: alarm_clr clears both flags and restarts both timeouts. A flag whose input is still stuck sets again once a full timeout has passed.
- R5: With man_ovr low, if the selected input is flagged bad and the other input is not, sel_out toggles on the next monitor edge.
- R6: A failure of the unselected input leaves sel_out unchanged.
- R7: With man_ovr low, if both flags are set, sel_out does not change.
- R8: While man_ovr is high, sel_out takes the value of sel_pref one edge later, and flags do not move it.
- R9: mrst, which is synchronous to mon_clk, clears both flags, drives clk_out low and loads sel_out from sel_pref.
- R10: Once settled, clk_out repeats the selected input as sampled two monitor edges earlier. The internal source of clk_out changes only in a cycle where clk_out is low.
- R11: sel_out encodes the selected input: 0 means ref_a and 1 means ref_b. sel_pref uses the same encoding.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| mon_clk | input | 1 | free-running monitor clock, faster than both references |
| mrst | input | 1 | synchronous master reset, active high |
| ref_a | input | 1 | redundant reference input 0 |
| ref_b | input | 1 | redundant reference input 1 |
| sel_pref | input | 1 | preferred or manually chosen source (0 = ref_a) |
| man_ovr | input | 1 | manual override, active high |
| alarm_clr | input | 1 | clears the bad flags, active high |
| sel_out | output | 1 | currently selected source (0 = ref_a) |
| bad_a | output | 1 | sticky failure flag for ref_a |
| bad_b | output | 1 | sticky failure flag for ref_b |
| clk_out | output | 1 | glitch-free selected reference, retimed to mon_clk |

## Verification
The properties assume that mrst, man_ovr, sel_pref and alarm_clr are synchronous to mon_clk. They also assume that mrst is high from time zero, so that every register holds a known value before any property is enabled. The references are treated as asynchronous. The stimulus toggles them only at times that fall between monitor edges, and always with half-periods well under the nominal timeout. Because of this, only a deliberate stop is ever seen as a failure. Stuck inputs are started from a known reset so that the order in which the flags rise is determined.

// File: rtl/redclk_pkg.sv
package redclk_pkg;
   typedef enum logic {
      MX_ON   = 1'b0,
      MX_DARK = 1'b1
   } mx_state_e;

   localparam int unsigned NUM_REFS = 2;
endpackage

// File: rtl/rc_sync.sv
module rc_sync #(
   parameter int unsigned STAGES = 2
) (
   input  logic clk,
   input  logic rst,
   input  logic d,
   output logic q
);
   logic [STAGES-1:0] chain;

   always_ff @(posedge clk) begin
      if (rst) chain <= '0;
      else     chain <= {chain[STAGES-2:0], d};
   end

   assign q = chain[STAGES-1];
endmodule

// File: rtl/rc_watch.sv
module rc_watch #(
   parameter int unsigned NOM_PERIOD  = 16,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic mrst,
   input  logic clr,
   input  logic ref_in,
   output logic lvl,
   output logic bad
);
   localparam int unsigned CNT_W = $clog2(NOM_PERIOD + 1);
   localparam logic [CNT_W-1:0] LIMIT = CNT_W'(NOM_PERIOD);

   logic             prev_lvl;
   logic             toggled;
   logic [CNT_W-1:0] quiet_cnt;

   rc_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk (clk),
      .rst (mrst),
      .d   (ref_in),
      .q   (lvl)
   );

   assign toggled = lvl ^ prev_lvl;

   always_ff @(posedge clk) begin
      if (mrst) prev_lvl <= 1'b0;
      else      prev_lvl <= lvl;
   end

   always_ff @(posedge clk) begin
      if (mrst || clr || toggled) quiet_cnt <= '0;
      else if (quiet_cnt != LIMIT) quiet_cnt <= quiet_cnt + 1'b1;
   end

   always_ff @(posedge clk) begin
      if (mrst || clr)             bad <= 1'b0;
      else if (quiet_cnt == LIMIT) bad <= 1'b1;
   end
endmodule

// File: rtl/rc_select.sv
module rc_select (
   input  logic       clk,
   input  logic       mrst,
   input  logic       sel_pref,
   input  logic       man_ovr,
   input  logic [1:0] bad,
   output logic       sel_q
);
   logic cur_bad;
   logic alt_bad;

   assign cur_bad = bad[sel_q];
   assign alt_bad = bad[~sel_q];

   always_ff @(posedge clk) begin
      if (mrst || man_ovr)      sel_q <= sel_pref;
      else if (cur_bad && !alt_bad) sel_q <= ~sel_q;
   end
endmodule

// File: rtl/rc_outmux.sv
module rc_outmux
   import redclk_pkg::*;
(
   input  logic       clk,
   input  logic       mrst,
   input  logic       sel,
   input  logic [1:0] lvl,
   input  logic [1:0] bad,
   output logic       src,
   output logic       out_q
);
   mx_state_e state;

   always_ff @(posedge clk) begin
      if (mrst) begin
         state <= MX_DARK;
         src   <= 1'b0;
         out_q <= 1'b0;
      end else begin
         case (state)
            MX_ON: begin
               if (sel != src && (!lvl[src] || bad[src])) begin
                  state <= MX_DARK;
                  src   <= sel;
                  out_q <= 1'b0;
               end else begin
                  out_q <= lvl[src];
               end
            end
            default: begin
               src   <= sel;
               out_q <= 1'b0;
               if (!lvl[sel]) state <= MX_ON;
            end
         endcase
      end
   end
endmodule

// File: rtl/redclk_switch.sv
module redclk_switch #(
   parameter int unsigned NOM_PERIOD  = 16,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic mon_clk,
   input  logic mrst,
   input  logic ref_a,
   input  logic ref_b,
   input  logic sel_pref,
   input  logic man_ovr,
   input  logic alarm_clr,
   output logic sel_out,
   output logic bad_a,
   output logic bad_b,
   output logic clk_out
);
   import redclk_pkg::*;

   logic [NUM_REFS-1:0] ref_vec;
   logic [NUM_REFS-1:0] lvl_vec;
   logic [NUM_REFS-1:0] bad_vec;
   logic                sel_q;
   logic                mux_src;

   if (NOM_PERIOD < 4) begin : g_chk_period
      $error("NOM_PERIOD must be at least 4 monitor cycles");
   end
   if (SYNC_STAGES < 2) begin : g_chk_sync
      $error("SYNC_STAGES must be at least 2");
   end

   assign ref_vec = {ref_b, ref_a};

   for (genvar i = 0; i < NUM_REFS; i++) begin : g_watch
      rc_watch #(
         .NOM_PERIOD  (NOM_PERIOD),
         .SYNC_STAGES (SYNC_STAGES)
      ) u_watch (
         .clk    (mon_clk),
         .mrst   (mrst),
         .clr    (alarm_clr),
         .ref_in (ref_vec[i]),
         .lvl    (lvl_vec[i]),
         .bad    (bad_vec[i])
      );
   end

   rc_select u_select (
      .clk      (mon_clk),
      .mrst     (mrst),
      .sel_pref (sel_pref),
      .man_ovr  (man_ovr),
      .bad      (bad_vec),
      .sel_q    (sel_q)
   );

   rc_outmux u_mux (
      .clk   (mon_clk),
      .mrst  (mrst),
      .sel   (sel_q),
      .lvl   (lvl_vec),
      .bad   (bad_vec),
      .src   (mux_src),
      .out_q (clk_out)
   );

   assign sel_out = sel_q;
   assign bad_a   = bad_vec[0];
   assign bad_b   = bad_vec[1];
endmodule

// File: rtl/redclk_switch_check.sv
module redclk_switch_check (
   input logic mon_clk,
   input logic mrst,
   input logic sel_pref,
   input logic man_ovr,
   input logic alarm_clr,
   input logic sel_out,
   input logic bad_a,
   input logic bad_b,
   input logic clk_out,
   input logic mux_src
);
   logic cur_bad;
   logic alt_bad;

   assign cur_bad = sel_out ? bad_b : bad_a;
   assign alt_bad = sel_out ? bad_a : bad_b;

   p_sticky_a_r3: assert property (@(posedge mon_clk) disable iff (mrst)
      (bad_a && !alarm_clr) |=> bad_a);

   p_sticky_b_r3: assert property (@(posedge mon_clk) disable iff (mrst)
      (bad_b && !alarm_clr) |=> bad_b);

   p_clear_r4: assert property (@(posedge mon_clk) disable iff (mrst)
      alarm_clr |=> (!bad_a && !bad_b));

   p_switch_r5: assert property (@(posedge mon_clk) disable iff (mrst)
      (!man_ovr && cur_bad && !alt_bad) |=> (sel_out != $past(sel_out)));

   p_keep_good_r6: assert property (@(posedge mon_clk) disable iff (mrst)
      (!man_ovr && !cur_bad) |=> $stable(sel_out));

   p_hold_both_r7: assert property (@(posedge mon_clk) disable iff (mrst)
      (!man_ovr && bad_a && bad_b) |=> $stable(sel_out));

   p_override_r8: assert property (@(posedge mon_clk) disable iff (mrst)
      man_ovr |=> (sel_out == $past(sel_pref)));

   p_no_runt_r10: assert property (@(posedge mon_clk) disable iff (mrst)
      (mux_src != $past(mux_src)) |-> !clk_out);
endmodule

bind redclk_switch redclk_switch_check u_check (
   .mon_clk   (mon_clk),
   .mrst      (mrst),
   .sel_pref  (sel_pref),
   .man_ovr   (man_ovr),
   .alarm_clr (alarm_clr),
   .sel_out   (sel_out),
   .bad_a     (bad_a),
   .bad_b     (bad_b),
   .clk_out   (clk_out),
   .mux_src   (mux_src)
);

// File: tb/redclk_switch_test.sv
`timescale 1ns/1ps
module redclk_switch_test;
   logic mon_clk = 1'b0;
   logic mrst = 1'b1;
   logic ref_a = 1'b0;
   logic ref_b = 1'b0;
   logic sel_pref = 1'b0;
   logic man_ovr = 1'b0;
   logic alarm_clr = 1'b0;
   logic sel_out, bad_a, bad_b, clk_out;

   logic run_a = 1'b1, run_b = 1'b1;
   logic stuck_a = 1'b0, stuck_b = 1'b0;

   int checks = 0;
   int fails = 0;
   bit done = 1'b0;

   bit exp_q[$];
   bit chk_on = 1'b0;
   bit chk_src = 1'b0;
   int cmp_cnt = 0;
   int mism_cnt = 0;

   redclk_switch #(.NOM_PERIOD(16), .SYNC_STAGES(2)) uut (
      .mon_clk   (mon_clk),
      .mrst      (mrst),
      .ref_a     (ref_a),
      .ref_b     (ref_b),
      .sel_pref  (sel_pref),
      .man_ovr   (man_ovr),
      .alarm_clr (alarm_clr),
      .sel_out   (sel_out),
      .bad_a     (bad_a),
      .bad_b     (bad_b),
      .clk_out   (clk_out)
   );

   initial forever #2.5 mon_clk = ~mon_clk;

   initial forever begin
      #20;
      if (run_a) ref_a = ~ref_a;
      else       ref_a = stuck_a;
   end

   initial forever begin
      #15;
      if (run_b) ref_b = ~ref_b;
      else       ref_b = stuck_b;
   end

   // driver side of the scoreboard: expected output level per edge
   always @(posedge mon_clk) begin
      if (chk_on) exp_q.push_back(chk_src ? ref_b : ref_a);
   end

   // monitor side: pop the value from two edges back and compare
   always @(negedge mon_clk) begin
      if (chk_on && exp_q.size() >= 3) begin
         cmp_cnt++;
         if (clk_out != exp_q.pop_front()) mism_cnt++;
      end
   end

   task automatic tick(input int n);
      repeat (n) @(negedge mon_clk);
   endtask

   task automatic check(input string req, input logic act, input logic exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual %b expected %b", req, act, exp);
      end
   endtask

   task automatic pulse_clr();
      alarm_clr = 1'b1;
      tick(1);
      alarm_clr = 1'b0;
   endtask

   task automatic clk_window(input string req, input bit src, input int n);
      exp_q.delete();
      cmp_cnt = 0;
      mism_cnt = 0;
      chk_src = src;
      chk_on = 1'b1;
      tick(n);
      chk_on = 1'b0;
      checks++;
      if (mism_cnt != 0 || cmp_cnt == 0) begin
         fails++;
         $display("FAIL %s: actual %0d mismatches in %0d samples expected 0 mismatches",
                  req, mism_cnt, cmp_cnt);
      end
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   endtask

   initial begin
      #(200000 * 5);
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

   initial begin
      // R9 reset state, R11 encoding
      sel_pref = 1'b0;
      tick(5);
      check("R9 clk_out low in reset", clk_out, 1'b0);
      check("R9 bad_a cleared", bad_a, 1'b0);
      check("R11 sel_out=0 selects ref_a", sel_out, 1'b0);
      mrst = 1'b0;
      tick(60);
      check("R2 running ref_a not flagged", bad_a, 1'b0);
      check("R2 running ref_b not flagged", bad_b, 1'b0);
      clk_window("R10 clk_out follows ref_a", 1'b0, 60);

      // R1/R2/R6: unselected input stuck low
      stuck_b = 1'b0; run_b = 1'b0;
      tick(40);
      check("R1 R2 unselected stuck-low flagged", bad_b, 1'b1);
      check("R6 no switch on unselected failure", sel_out, 1'b0);

      // R3: flag sticky after recovery
      run_b = 1'b1;
      tick(40);
      check("R3 flag held after recovery", bad_b, 1'b1);
      pulse_clr();
      tick(40);
      check("R4 clear drops flag of healthy input", bad_b, 1'b0);

      // R5/R2: selected input stuck high, switch to ref_b
      stuck_a = 1'b1; run_a = 1'b0;
      tick(40);
      check("R2 stuck-high flagged", bad_a, 1'b1);
      check("R5 switched to ref_b", sel_out, 1'b1);
      tick(10);
      clk_window("R10 clk_out follows ref_b after switch", 1'b1, 60);

      // R4: clear while still stuck, flag returns after timeout
      pulse_clr();
      check("R4 flag cleared by alarm_clr", bad_a, 1'b0);
      tick(40);
      check("R4 stuck input flagged again", bad_a, 1'b1);
      check("R5 selection kept on good ref_b", sel_out, 1'b1);

      // R7: both bad, selection held
      stuck_b = 1'b0; run_b = 1'b0;
      tick(40);
      check("R7 both flagged", bad_b, 1'b1);
      check("R7 selection held at ref_b", sel_out, 1'b1);

      // R9: master reset with both stuck
      sel_pref = 1'b0;
      mrst = 1'b1;
      tick(2);
      check("R9 bad_a cleared by mrst", bad_a, 1'b0);
      check("R9 bad_b cleared by mrst", bad_b, 1'b0);
      check("R9 selection loaded from sel_pref", sel_out, 1'b0);
      mrst = 1'b0;
      tick(40);
      check("R7 both flagged after reset", bad_a & bad_b, 1'b1);
      check("R7 selection stays on ref_a", sel_out, 1'b0);

      // R8: manual override
      run_a = 1'b1; run_b = 1'b1;
      tick(10);
      pulse_clr();
      man_ovr = 1'b1; sel_pref = 1'b1;
      tick(2);
      check("R8 override selects ref_b", sel_out, 1'b1);
      stuck_b = 1'b1; run_b = 1'b0;
      tick(40);
      check("R8 flag still raised under override", bad_b, 1'b1);
      check("R8 no auto switch under override", sel_out, 1'b1);
      sel_pref = 1'b0;
      tick(2);
      check("R8 override follows sel_pref to ref_a", sel_out, 1'b0);
      man_ovr = 1'b0;
      run_b = 1'b1;
      tick(10);
      pulse_clr();
      tick(10);
      check("R6 stays on healthy ref_a", sel_out, 1'b0);
      clk_window("R10 clk_out follows ref_a at end", 1'b0, 60);

      finish_run();
   end
endmodule